// File: doc/BRIEF.md
# Serial 1-1-0 Pattern Detector, Moore and Mealy Pair

This block samples one serial bit on every rising clock edge and flags the pattern 1, 1, 0 on consecutive samples. Two independent finite state machines watch the same stream. One is a Moore machine: its flag depends only on its registered state. The other is a Mealy machine: its flag depends on its state and on the bit currently present at the input.

Both machines share one clock and one synchronous active-low reset, which returns them to their idle state. Because both machines track the same stream, the Mealy flag goes high while the final 0 is still at the input. The Moore flag goes high one cycle later, after that 0 has been clocked in. Both state registers are brought out as ports, so the fixed encodings can be observed and the timing gap between the two styles can be compared directly.

Top module: `dual_seq_detect`

## Requirements
- R1: The Moore state port uses idle=00, one-seen=01, two-seen=11 and found=10. Transitions: idle goes to one-seen on 1 and stays on 0. One-seen goes to two-seen on 1 and to idle on 0. Two-seen goes to found on 0.
- R2: `moore_hit` is 1 exactly when the Moore state is found (10), which is the cycle after the edge that samples the closing 0.
- R3: Overlapping patterns are detected. Two-seen stays in two-seen on 1. Found goes to one-seen on 1 and to idle on 0, so the stream 1,1,0,1,1,0 gives two Moore hits.
- R4: The Mealy state port uses idle=00, one-seen=01 and two-seen=11. Its low state bit takes the sampled input. Idle and one-seen step forward on 1. One-seen goes to idle on 0. Two-seen holds on 1 and goes to idle on 0. The code 10 never appears.
- R5: `mealy_hit` equals (Mealy state is 11) AND (`bit_in` is 0) within the same cycle, with no register in between.
- R6: For any stream, every Mealy hit is followed by a Moore hit in the next cycle.
- R7: Reset is synchronous and active low. When `rst_n` is low at a rising edge, both states become 00 and both flags are low. Pulling `rst_n` low between edges changes nothing until the next edge.
- R8: A run of several 1s followed by a single 0 yields exactly one hit on each flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock that samples `bit_in` |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_in | input | 1 | Serial data bit |
| moore_hit | output | 1 | Moore detect flag, registered state decode |
| mealy_hit | output | 1 | Mealy detect flag, combinational in the current input |
| moore_state | output | 2 | Current Moore state code |
| mealy_state | output | 2 | Current Mealy state code |

## Verification
The bench drives every 8-bit stream from a fresh reset. Any state and suffix the detectors can reach appears within those streams, so a wrong transition or a wrong state code cannot go unnoticed. Separate directed streams isolate overlap (1,1,0,1,1,0), long runs of 1s before a 0, and a back-to-back Mealy/Moore pair, which separates the one-cycle gap of R6 from a plain detection error. A reset pulled low mid-cycle while the machines sit in two-seen shows whether the reset waits for the clock edge.

// File: rtl/seqdet_pkg.sv
// Package seqdet_pkg
// Shared state codes for both 1-1-0 detectors.
// Assumes a two-bit state vector for each machine.
package seqdet_pkg;
    localparam int unsigned ST_W = 2;
    typedef logic [ST_W-1:0] st_t;

    // Moore codes
    localparam st_t MO_IDLE  = 2'b00;
    localparam st_t MO_ONE   = 2'b01;
    localparam st_t MO_TWO   = 2'b11;
    localparam st_t MO_FOUND = 2'b10;

    // Mealy codes (10 is not a legal state)
    localparam st_t ME_IDLE  = 2'b00;
    localparam st_t ME_ONE   = 2'b01;
    localparam st_t ME_TWO   = 2'b11;
    localparam st_t ME_BAD   = 2'b10;
endpackage

// File: rtl/seq_state_reg.sv
// Module seq_state_reg
// A generic state register with synchronous active-low reset to a
// parameterised idle code. Assumes a single rising-edge clock.
module seq_state_reg #(
    parameter int unsigned W = 2,
    parameter logic [W-1:0] IDLE = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] nxt,
    output logic [W-1:0] cur
);
    // Hold state, or load the idle code when reset is low at the edge.
    always_ff @(posedge clk) begin
        if (!rst_n) cur <= IDLE;
        else        cur <= nxt;
    end
endmodule

// File: rtl/moore_110_fsm.sv
// Module moore_110_fsm
// Moore detector for 1-1-0. The flag is a decode of the state alone.
// Assumes bit_in is stable around the rising clock edge.
module moore_110_fsm
    import seqdet_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    output logic hit,
    output st_t  state
);
    st_t nxt;

    // Next-state selection; overlapping patterns are kept.
    always_comb begin
        unique case (state)
            MO_IDLE:  nxt = bit_in ? MO_ONE : MO_IDLE;
            MO_ONE:   nxt = bit_in ? MO_TWO : MO_IDLE;
            MO_TWO:   nxt = bit_in ? MO_TWO : MO_FOUND;
            MO_FOUND: nxt = bit_in ? MO_ONE : MO_IDLE;
            default:  nxt = MO_IDLE;
        endcase
    end

    seq_state_reg #(.W(ST_W), .IDLE(MO_IDLE)) st_reg_i (
        .clk(clk), .rst_n(rst_n), .nxt(nxt), .cur(state)
    );

    // Flag is high only in the found state.
    always_comb hit = (state == MO_FOUND);
endmodule

// File: rtl/mealy_110_fsm.sv
// Module mealy_110_fsm
// Mealy detector for 1-1-0. The flag depends on state and present input.
// Assumes bit_in settles before the edge; the flag follows it in-cycle.
module mealy_110_fsm
    import seqdet_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    output logic hit,
    output st_t  state
);
    st_t nxt;

    // Low bit tracks the input; high bit is set after two 1s; code 10 recovers.
    always_comb begin
        if (state == ME_BAD) nxt = ME_IDLE;
        else                 nxt = {state[0] & bit_in, bit_in};
    end

    seq_state_reg #(.W(ST_W), .IDLE(ME_IDLE)) st_reg_i (
        .clk(clk), .rst_n(rst_n), .nxt(nxt), .cur(state)
    );

    // Flag: two ones seen and a zero is present now.
    always_comb hit = state[1] & state[0] & ~bit_in;
endmodule

// File: rtl/dual_seq_detect.sv
// Module dual_seq_detect
// Top level: a Moore and a Mealy 1-1-0 detector on one serial input.
// Assumes one clock domain and a synchronous active-low reset.
module dual_seq_detect
    import seqdet_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_in,
    output logic       moore_hit,
    output logic       mealy_hit,
    output logic [1:0] moore_state,
    output logic [1:0] mealy_state
);
    moore_110_fsm moore_i (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in),
        .hit(moore_hit), .state(moore_state)
    );

    mealy_110_fsm mealy_i (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in),
        .hit(mealy_hit), .state(mealy_state)
    );
endmodule

// File: rtl/dual_seq_detect_chk.sv
// Module dual_seq_detect_chk
// Property checker for dual_seq_detect, attached by bind below.
// Assumes the bench holds rst_n low from time zero.
module dual_seq_detect_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_in,
    input logic       moore_hit,
    input logic       mealy_hit,
    input logic [1:0] moore_state,
    input logic [1:0] mealy_state
);
    // Reset at an edge clears both machines.
    p_reset_idle_r7: assert property (@(posedge clk)
        !rst_n |=> (moore_state == 2'b00 && mealy_state == 2'b00 && !moore_hit));

    // A Mealy hit is followed by a Moore hit.
    p_mealy_leads_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && mealy_hit) |=> moore_hit);

    // The Moore found state lasts a single cycle.
    p_found_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
        moore_hit |=> !moore_hit);

    // The Moore hit comes after a sampled zero.
    p_moore_after_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        moore_hit |-> $past(!bit_in));

    // The Mealy hit needs a zero at the input.
    p_mealy_zero_in_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mealy_hit |-> !bit_in);

    // The Mealy code 10 never appears.
    p_mealy_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mealy_state != 2'b10);

    // Mealy low bit follows the previous input.
    p_mealy_low_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (mealy_state[0] == $past(bit_in)));
endmodule

bind dual_seq_detect dual_seq_detect_chk chk_i (.*);

// File: tb/dual_seq_detect_tb_top.sv
// Bench for dual_seq_detect: exhaustive 8-bit streams plus directed cases.
module dual_seq_detect_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_in = 1'b0;
    logic       moore_hit, mealy_hit;
    logic [1:0] moore_state, mealy_state;

    int total = 0;
    int bad = 0;
    logic [2:0] hist = 3'b000;   // sampled bits, newest in bit 0

    always #10 clk = ~clk;       // 50 MHz

    dual_seq_detect dut_i (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in),
        .moore_hit(moore_hit), .mealy_hit(mealy_hit),
        .moore_state(moore_state), .mealy_state(mealy_state)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [1:0] exp_moore_st(input logic [2:0] h);
        if (h == 3'b110)      return 2'b10;
        if (h[1:0] == 2'b11)  return 2'b11;
        if (h[0])             return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic [1:0] exp_mealy_st(input logic [2:0] h);
        if (h[1:0] == 2'b11)  return 2'b11;
        if (h[0])             return 2'b01;
        return 2'b00;
    endfunction

    // Drive one bit mid-cycle, check all outputs, then clock it in.
    task automatic step(input logic b, input string moore_tag);
        logic em, ee;
        @(negedge clk);
        bit_in = b;
        #1;
        em = (hist == 3'b110);
        ee = (hist[1:0] == 2'b11) && !b;
        check(moore_state == exp_moore_st(hist), "R1 moore_state", moore_state, exp_moore_st(hist));
        check(mealy_state == exp_mealy_st(hist), "R4 mealy_state", mealy_state, exp_mealy_st(hist));
        check(moore_hit == em, moore_tag, moore_hit, em);
        check(mealy_hit == ee, "R5 mealy_hit", mealy_hit, ee);
        @(posedge clk);
        hist = {hist[1:0], b};
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bit_in = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        hist = 3'b000;
        #1;
        check(moore_state == 2'b00 && mealy_state == 2'b00, "R7 states after reset",
              {moore_state, mealy_state}, 0);
        check(!moore_hit && !mealy_hit, "R7 flags after reset", {moore_hit, mealy_hit}, 0);
    endtask

    // Count hits of each flag over a stream; return both counts.
    task automatic run_count(input logic [15:0] s, input int n, input string tag,
                             output int nmo, output int nme);
        nmo = 0;
        nme = 0;
        for (int i = n - 1; i >= 0; i--) begin
            step(s[i], tag);
            if (mealy_hit) nme++;
            if (moore_hit) nmo++;
        end
        step(1'b0, tag);
        if (moore_hit) nmo++;
    endtask

    initial begin
        int nmo, nme;
        do_reset();

        // Exhaustive 8-bit streams from reset.
        for (int v = 0; v < 256; v++) begin
            do_reset();
            for (int i = 7; i >= 0; i--) step(v[i], "R2 moore_hit");
        end

        // Overlap: 1,1,0,1,1,0 gives two hits each.
        do_reset();
        run_count(16'b110110, 6, "R3 moore_hit overlap", nmo, nme);
        check(nmo == 2, "R3 moore overlap count", nmo, 2);
        check(nme == 2, "R3 mealy overlap count", nme, 2);

        // Long run of ones then a single zero.
        do_reset();
        run_count(16'b1111111110, 10, "R8 moore_hit run", nmo, nme);
        check(nmo == 1, "R8 moore run count", nmo, 1);
        check(nme == 1, "R8 mealy run count", nme, 1);

        // One-cycle lead: Mealy in the zero cycle, Moore right after.
        do_reset();
        step(1'b1, "R6 moore_hit");
        step(1'b1, "R6 moore_hit");
        @(negedge clk);
        bit_in = 1'b0;
        #1;
        check(mealy_hit == 1'b1, "R6 mealy high first", mealy_hit, 1);
        check(moore_hit == 1'b0, "R6 moore still low", moore_hit, 0);
        @(posedge clk);
        hist = {hist[1:0], 1'b0};
        @(negedge clk);
        bit_in = 1'b1;
        #1;
        check(moore_hit == 1'b1, "R6 moore high next", moore_hit, 1);
        check(mealy_hit == 1'b0, "R6 mealy low next", mealy_hit, 0);
        @(posedge clk);
        hist = {hist[1:0], 1'b1};

        // Reset pulled low mid-cycle waits for the edge.
        step(1'b1, "R2 moore_hit");
        @(negedge clk);
        rst_n = 1'b0;
        bit_in = 1'b1;
        #1;
        check(moore_state == 2'b11, "R7 moore held before edge", moore_state, 3);
        check(mealy_state == 2'b11, "R7 mealy held before edge", mealy_state, 3);
        @(posedge clk);
        #1;
        check(moore_state == 2'b00 && mealy_state == 2'b00, "R7 cleared at edge",
              {moore_state, mealy_state}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        hist = 3'b000;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule